// File: doc/BRIEF.md
# Rotating-Cipher Serial Receiver

This block collects one byte from a serial sender, one bit per request/acknowledge exchange on a single data line. Each exchange is a full four-phase handshake. Once eight bits are in, the block waits for the sender to say its key is ready. It then undoes the sender's right-rotation cipher by rotating the assembled byte left, one position per clock, until a small step counter matches the low three bits of the shared 4-bit key.

The recovered byte goes to a user as two nibbles, low nibble first. Each nibble has its own four-phase request/acknowledge exchange. After the high nibble's exchange completes, the block goes back to waiting for the next serial bit.

Every handshake input from outside (send request, key ready, user acknowledge) passes through a two-flop synchronizer before the controller sees it. A synchronous active-high reset returns the block to its idle bit-wait state.

Top module: `cipher_rx`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `dataAck` and `outReq` are 0. The assembled byte is cleared, so `outNibble` reads 0.
- R2: When `sendReq` is high before a clock edge, the bit on `dataBit` is captured at the MSB of the byte, and the byte shifts right by one. `dataAck` rises exactly three clock edges after `sendReq` is first sampled high. The first bit received ends up in bit 0 of the byte.
- R3: `dataAck` stays high until `sendReq` has been seen low. It then falls exactly three clock edges after `sendReq` is first sampled low.
- R4: After exactly eight captured bits, no further bit is accepted and `dataAck` stays 0. `outReq` stays 0 for as long as `keyReady` is low.
- R5: After `keyReady` is seen high, the byte is rotated left by `key[2:0]` positions. `key[3]` has no effect, so keys k and k+8 give the same result.
- R6: The low nibble (byte bits 3:0) is shown on `outNibble` with `outReq` high. `outReq` stays high, and `outNibble` stays stable, until `userAck` is seen high. `outReq` then drops, and the block waits for `userAck` to be seen low.
- R7: Next, the high nibble (byte bits 7:4) is shown with the same handshake. After that, the block accepts a new serial bit.
- R8: `dataAck` and `outReq` are never high at the same time. A change on any handshake input reaches the outputs no sooner than three clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sendReq | input | 1 | Sender's bit request (asynchronous) |
| dataBit | input | 1 | Serial data bit, held stable while `sendReq` is high |
| keyReady | input | 1 | Sender's key-ready indication (asynchronous) |
| key | input | 4 | Shared cipher key; only bits 2:0 are used |
| dataAck | output | 1 | Acknowledge to the sender for a captured bit |
| userAck | input | 1 | User's acknowledge for a shown nibble (asynchronous) |
| outNibble | output | 4 | Nibble presented to the user |
| outReq | output | 1 | Request telling the user a nibble is valid |

## Verification
On every cycle, the assertions check that the two requests are mutually exclusive and that the shown nibble holds steady while its request is up. They also check that each edge of `dataAck` and `outReq` follows the matching handshake input as it stood two edges earlier. The bench's scenarios are needed for the rest: the exact three-edge latency, the bit order into the byte, the stall while key-ready is low, and the correct recovery of a byte for every key from 0 to 15 in a loopback against a behavioural sender.

// File: rtl/cipher_rx_pkg.sv
package cipher_rx_pkg;

  typedef enum logic [2:0] {
    ST_BIT_WAIT,
    ST_BIT_ACK,
    ST_KEY_WAIT,
    ST_ROTATE,
    ST_LO_SHOW,
    ST_LO_DROP,
    ST_HI_SHOW,
    ST_HI_DROP
  } rxState_t;

  typedef struct packed {
    logic shiftIn;  // capture serial bit at MSB, shift right
    logic rotLeft;  // one left rotation step
    logic clrRot;   // zero the rotation step counter
    logic hiSel;    // show the high nibble
  } rxStrobe_t;

endpackage

// File: rtl/cipher_rx_sync.sv
module cipher_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/cipher_rx_dp.sv
module cipher_rx_dp
  import cipher_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int KEY_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  rxStrobe_t           strb,
  input  logic                dataBit,
  input  logic [KEY_W-1:0]    key,
  output logic                bitWrap,
  output logic                rotHit,
  output logic [DATA_W/2-1:0] nibbleOut
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] word;
  logic [CNT_W-1:0]  bitCnt;
  logic [CNT_W-1:0]  rotCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      word   <= '0;
      bitCnt <= '0;
      rotCnt <= '0;
    end else begin
      if (strb.shiftIn) begin
        word   <= {dataBit, word[DATA_W-1:1]};
        bitCnt <= bitCnt + 1'b1;
      end else if (strb.rotLeft) begin
        word   <= {word[DATA_W-2:0], word[DATA_W-1]};
      end
      if (strb.clrRot)       rotCnt <= '0;
      else if (strb.rotLeft) rotCnt <= rotCnt + 1'b1;
    end
  end

  // Counter wraps to zero after a full byte of captures.
  assign bitWrap   = (bitCnt == '0);
  assign rotHit    = (rotCnt == key[CNT_W-1:0]);
  assign nibbleOut = strb.hiSel ? word[DATA_W-1 -: NIB_W] : word[NIB_W-1:0];

endmodule

// File: rtl/cipher_rx_ctrl.sv
module cipher_rx_ctrl
  import cipher_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      reqS,
  input  logic      keyS,
  input  logic      ackS,
  input  logic      bitWrap,
  input  logic      rotHit,
  output rxStrobe_t strb,
  output logic      dataAck,
  output logic      outReq
);

  rxState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_BIT_WAIT;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_BIT_WAIT: if (reqS)    nextState = ST_BIT_ACK;
      ST_BIT_ACK:  if (!reqS)   nextState = bitWrap ? ST_KEY_WAIT : ST_BIT_WAIT;
      ST_KEY_WAIT: if (keyS)    nextState = ST_ROTATE;
      ST_ROTATE:   if (rotHit)  nextState = ST_LO_SHOW;
      ST_LO_SHOW:  if (ackS)    nextState = ST_LO_DROP;
      ST_LO_DROP:  if (!ackS)   nextState = ST_HI_SHOW;
      ST_HI_SHOW:  if (ackS)    nextState = ST_HI_DROP;
      ST_HI_DROP:  if (!ackS)   nextState = ST_BIT_WAIT;
      default:                  nextState = ST_BIT_WAIT;
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.shiftIn = (state == ST_BIT_WAIT) && reqS;
    strb.clrRot  = (state == ST_KEY_WAIT) && keyS;
    strb.rotLeft = (state == ST_ROTATE) && !rotHit;
    strb.hiSel   = (state == ST_HI_SHOW) || (state == ST_HI_DROP);
  end

  assign dataAck = (state == ST_BIT_ACK);
  assign outReq  = (state == ST_LO_SHOW) || (state == ST_HI_SHOW);

endmodule

// File: rtl/cipher_rx.sv
module cipher_rx
  import cipher_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int KEY_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sendReq,
  input  logic                dataBit,
  input  logic                keyReady,
  input  logic [KEY_W-1:0]    key,
  output logic                dataAck,
  input  logic                userAck,
  output logic [DATA_W/2-1:0] outNibble,
  output logic                outReq
);

  logic [2:0] syncd;
  rxStrobe_t  strb;
  logic       bitWrap;
  logic       rotHit;

  cipher_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn ({userAck, keyReady, sendReq}),
    .syncOut (syncd)
  );

  cipher_rx_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .reqS    (syncd[0]),
    .keyS    (syncd[1]),
    .ackS    (syncd[2]),
    .bitWrap (bitWrap),
    .rotHit  (rotHit),
    .strb    (strb),
    .dataAck (dataAck),
    .outReq  (outReq)
  );

  cipher_rx_dp #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .dataBit   (dataBit),
    .key       (key),
    .bitWrap   (bitWrap),
    .rotHit    (rotHit),
    .nibbleOut (outNibble)
  );

endmodule

// File: rtl/cipher_rx_chk.sv
module cipher_rx_chk #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sendReq,
  input logic             userAck,
  input logic             dataAck,
  input logic             outReq,
  input logic [NIB_W-1:0] outNibble
);

  a_r8_req_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(dataAck && outReq));

  a_r6_nibble_stable: assert property (@(posedge clk) disable iff (rst)
    (outReq && $past(outReq)) |-> $stable(outNibble));

  a_r2_ack_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(dataAck) |-> $past(sendReq, 2));

  a_r3_ack_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(dataAck) |-> !$past(sendReq, 2));

  a_r7_req_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(outReq) |-> !$past(userAck, 2));

  a_r6_req_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(outReq) |-> $past(userAck, 2));

endmodule

bind cipher_rx cipher_rx_chk #(.NIB_W(DATA_W/2)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sendReq   (sendReq),
  .userAck   (userAck),
  .dataAck   (dataAck),
  .outReq    (outReq),
  .outNibble (outNibble)
);

// File: tb/tb_cipher_rx.sv
`timescale 1ns/1ps
module tb_cipher_rx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sendReq = 1'b0;
  logic       dataBit = 1'b0;
  logic       keyReady = 1'b0;
  logic [3:0] key = 4'd0;
  logic       userAck = 1'b0;
  logic       dataAck;
  logic [3:0] outNibble;
  logic       outReq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic       prevReq = 1'b0;
  logic [3:0] prevNib = 4'd0;

  always #4 clk = ~clk;  // 125 MHz

  cipher_rx dut (
    .clk(clk), .rst(rst), .sendReq(sendReq), .dataBit(dataBit),
    .keyReady(keyReady), .key(key), .dataAck(dataAck), .userAck(userAck),
    .outNibble(outNibble), .outReq(outReq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Per-clock model of output rules, sampled mid-cycle.
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      finishRun();
    end
    if (!rst) begin
      check("R8 exclusive", {7'd0, dataAck && outReq}, 8'd0);
      if (outReq && prevReq) check("R6 stable nibble", {4'd0, outNibble}, {4'd0, prevNib});
    end
    prevReq = outReq;
    prevNib = outNibble;
  end

  // Behavioural sender cipher: rotate right by key mod 8.
  function automatic logic [7:0] encrypt(input logic [7:0] b, input int k);
    logic [7:0] r = b;
    for (int i = 0; i < k % 8; i++) r = {r[0], r[7:1]};
    return r;
  endfunction

  task automatic sendBit(input logic b);
    @(negedge clk);
    sendReq = 1'b1; dataBit = b;
    repeat (2) @(negedge clk);
    check("R2 ack not early", {7'd0, dataAck}, 8'd0);
    @(negedge clk);
    check("R2 ack after three edges", {7'd0, dataAck}, 8'd1);
    sendReq = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 ack held", {7'd0, dataAck}, 8'd1);
    @(negedge clk);
    check("R3 ack drops after three edges", {7'd0, dataAck}, 8'd0);
  endtask

  task automatic waitReq(input logic lvl, input string req);
    int n = 0;
    while (outReq !== lvl && n < 64) begin
      @(negedge clk); n++;
    end
    check(req, {7'd0, outReq}, {7'd0, lvl});
  endtask

  task automatic runByte(input logic [7:0] plain, input int k, input logic stall);
    logic [7:0] cipher = encrypt(plain, k);
    for (int i = 0; i < 8; i++) sendBit(cipher[i]);  // LSB first
    if (stall) begin
      // R4: extra request is ignored and no output appears without key-ready.
      @(negedge clk); sendReq = 1'b1;
      repeat (12) @(negedge clk);
      check("R4 no ninth ack", {7'd0, dataAck}, 8'd0);
      check("R4 no output before key", {7'd0, outReq}, 8'd0);
      sendReq = 1'b0;
      repeat (4) @(negedge clk);
    end
    key = 4'(k); keyReady = 1'b1;
    waitReq(1'b1, "R5 low nibble request");
    keyReady = 1'b0;
    check($sformatf("R5 R6 low nibble key %0d", k), {4'd0, outNibble}, {4'd0, plain[3:0]});
    userAck = 1'b1;
    waitReq(1'b0, "R6 request drops on ack");
    repeat (4) @(negedge clk);
    check("R6 waits for ack low", {7'd0, outReq}, 8'd0);
    userAck = 1'b0;
    waitReq(1'b1, "R7 high nibble request");
    check($sformatf("R7 high nibble key %0d", k), {4'd0, outNibble}, {4'd0, plain[7:4]});
    userAck = 1'b1;
    waitReq(1'b0, "R7 high request drops");
    userAck = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ack in reset", {7'd0, dataAck}, 8'd0);
    check("R1 req in reset", {7'd0, outReq}, 8'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 nibble cleared", {4'd0, outNibble}, 8'd0);
    check("R1 ack after reset", {7'd0, dataAck}, 8'd0);
    runByte(8'hA5, 3, 1'b1);
    runByte(8'h81, 11, 1'b0);  // R5: key bit 3 ignored
    for (int k = 0; k < 16; k++) runByte(8'(8'h3C + k * 8'd37), k, 1'b0);
    runByte(8'h00, 7, 1'b0);
    runByte(8'hFF, 5, 1'b0);
    finishRun();
  end

endmodule